// File: doc/BRIEF.md
# Raster-Operation Read-Modify-Write Datapath

This block speeds up bit-block transfers in a bitmap. Software walks the rectangle one word at a time. For each destination word it issues one write request that carries the source word and the destination address. The block turns that request into a read-modify-write of the memory. It first aligns the source word to the destination word boundary with a funnel shifter. The funnel fills the vacated bit positions from the source word of the previous request. It then reads the destination word and combines the two with the selected Boolean function. Only the bits that the mask allows are written back; every other bit keeps its stored value.

The Boolean function, the mask and the shift amount come from a small register-write port. Their values are captured when a request is accepted, so a transaction in flight is not affected by later register writes. A line-start flag on the request clears the carried bits, so the first word of each scan line is not polluted by the last word of the line before. The memory port is a single synchronous port with one cycle of read latency.

Top module: `rop_rmw_engine`

## Requirements
- R1: After reset, `req_ready` is high and `mem_en` is low. The function is replace, the mask is all ones, the shift is zero and the carried word is zero.
- R2: A register write with `cfg_we` high updates one setting selected by `cfg_sel`. Code 0 sets the function from `cfg_wdata[1:0]`. Code 1 sets the mask from all of `cfg_wdata`. Code 2 sets the shift from the low log2(W) bits of `cfg_wdata`. Code 3 changes nothing.
- R3: The function codes are 0 for replace (s), 1 for paint (d OR s), 2 for invert (d XOR s) and 3 for erase (d AND NOT s). Here d is the stored destination word and s is the aligned source word.
- R4: The word written back is (F(d,s) AND mask) OR (d AND NOT mask).
- R5: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. In the next cycle the block drives a read (`mem_en`=1, `mem_we`=0) to the request address. In the cycle after that it drives a write (`mem_en`=1, `mem_we`=1) to the same address. `mem_en` is low whenever `req_ready` is high.
- R6: `req_ready` is low from the cycle after acceptance through the write-back cycle, and it is high again in the cycle after the write-back.
- R7: With shift amount k, let c = {previous word, current source}, 2W bits wide. Bit i of the aligned source is bit i+k of c.
- R8: When `req_line_start` is high on the accepted request, the previous word used by the funnel is zero.
- R9: Each accepted request stores its unshifted source word as the previous word for the next request.
- R10: The function, mask and aligned source used by a transaction are the values present when it was accepted. A register write during the transaction does not affect its result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 function, 1 mask, 2 shift, 3 none |
| cfg_wdata | input | W | Register write value |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Block can accept a request |
| req_line_start | input | 1 | Request is the first word of a line; clears the carry |
| req_addr | input | AW | Destination word address |
| req_src | input | W | Unshifted source word |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | W | Merged word written back |
| mem_rdata | input | W | Memory read data, valid one cycle after a read |

## Verification
The assertions assume that the memory returns the addressed word on `mem_rdata` in the cycle after the read. They also assume that the word stays there through the write-back cycle, since the mask check compares the written word against it bit by bit. The bench's memory model is a synchronous array with exactly one cycle of read latency, and it updates its read register only on enabled cycles. The bench raises `req_valid` for a single cycle, only while `req_ready` is high. It changes registers mid-transaction only in the test that targets R10.

// File: rtl/rop_pkg.sv
package rop_pkg;

    typedef enum logic [1:0] {
        ROP_REPLACE = 2'b00,
        ROP_PAINT   = 2'b01,
        ROP_INVERT  = 2'b10,
        ROP_ERASE   = 2'b11
    } rop_fn_e;

    typedef enum logic [1:0] {
        CFG_FN    = 2'b00,
        CFG_MASK  = 2'b01,
        CFG_SHIFT = 2'b10,
        CFG_NONE  = 2'b11
    } cfg_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_READ  = 2'b01,
        ST_WBACK = 2'b10
    } rmw_state_e;

endpackage

// File: rtl/rop_cfg_regs.sv
module rop_cfg_regs
    import rop_pkg::*;
#(
    parameter int W   = 32,
    parameter int SHW = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic [1:0]     cfg_sel,
    input  logic [W-1:0]   cfg_wdata,
    output rop_fn_e        fn,
    output logic [W-1:0]   mask,
    output logic [SHW-1:0] shamt
);

    typedef struct packed {
        rop_fn_e        fn;
        logic [W-1:0]   mask;
        logic [SHW-1:0] shamt;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            case (cfg_sel_e'(cfg_sel))
                CFG_FN:    cfg_d.fn    = rop_fn_e'(cfg_wdata[1:0]);
                CFG_MASK:  cfg_d.mask  = cfg_wdata;
                CFG_SHIFT: cfg_d.shamt = cfg_wdata[SHW-1:0];
                default:   cfg_d       = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.fn    <= ROP_REPLACE;
            cfg_q.mask  <= '1;
            cfg_q.shamt <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign fn    = cfg_q.fn;
    assign mask  = cfg_q.mask;
    assign shamt = cfg_q.shamt;

endmodule

// File: rtl/rop_funnel_shift.sv
module rop_funnel_shift #(
    parameter int W   = 32,
    parameter int SHW = 5
) (
    input  logic [W-1:0]   prev_word,
    input  logic [W-1:0]   cur_word,
    input  logic [SHW-1:0] shamt,
    output logic [W-1:0]   aligned
);

    localparam int CW = 2 * W;

    logic [CW-1:0] stage [SHW+1];

    assign stage[0] = {prev_word, cur_word};

    for (genvar k = 0; k < SHW; k++) begin : g_stage
        assign stage[k+1] = shamt[k] ? (stage[k] >> (1 << k)) : stage[k];
    end

    assign aligned = W'(stage[SHW]);

endmodule

// File: rtl/rop_logic_unit.sv
module rop_logic_unit
    import rop_pkg::*;
#(
    parameter int W = 32
) (
    input  rop_fn_e      fn,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] dst,
    input  logic [W-1:0] src,
    output logic [W-1:0] result
);

    logic [W-1:0] combined;

    always_comb begin
        case (fn)
            ROP_REPLACE: combined = src;
            ROP_PAINT:   combined = dst | src;
            ROP_INVERT:  combined = dst ^ src;
            ROP_ERASE:   combined = dst & ~src;
            default:     combined = src;
        endcase
        result = (combined & mask) | (dst & ~mask);
    end

endmodule

// File: rtl/rop_rmw_ctrl.sv
module rop_rmw_ctrl
    import rop_pkg::*;
#(
    parameter int W  = 32,
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_line_start,
    input  logic [AW-1:0] req_addr,
    input  logic [W-1:0]  req_src,
    input  logic [W-1:0]  aligned,
    input  rop_fn_e       cfg_fn,
    input  logic [W-1:0]  cfg_mask,
    output logic          req_ready,
    output logic [W-1:0]  carry_word,
    output rop_fn_e       op_fn,
    output logic [W-1:0]  op_mask,
    output logic [W-1:0]  op_src,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr
);

    typedef struct packed {
        rmw_state_e    st;
        logic [AW-1:0] addr;
        logic [W-1:0]  src;
        rop_fn_e       fn;
        logic [W-1:0]  mask;
        logic [W-1:0]  carry;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        case (ctl_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    ctl_d.st    = ST_READ;
                    ctl_d.addr  = req_addr;
                    ctl_d.src   = aligned;
                    ctl_d.fn    = cfg_fn;
                    ctl_d.mask  = cfg_mask;
                    ctl_d.carry = req_src;
                end
            end
            ST_READ:  ctl_d.st = ST_WBACK;
            ST_WBACK: ctl_d.st = ST_IDLE;
            default:  ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st    <= ST_IDLE;
            ctl_q.addr  <= '0;
            ctl_q.src   <= '0;
            ctl_q.fn    <= ROP_REPLACE;
            ctl_q.mask  <= '1;
            ctl_q.carry <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign req_ready  = (ctl_q.st == ST_IDLE);
    assign carry_word = req_line_start ? '0 : ctl_q.carry;
    assign op_fn      = ctl_q.fn;
    assign op_mask    = ctl_q.mask;
    assign op_src     = ctl_q.src;
    assign mem_en     = (ctl_q.st != ST_IDLE);
    assign mem_we     = (ctl_q.st == ST_WBACK);
    assign mem_addr   = ctl_q.addr;

endmodule

// File: rtl/rop_rmw_engine.sv
module rop_rmw_engine
    import rop_pkg::*;
#(
    parameter int W  = 32,
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [W-1:0]  cfg_wdata,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_line_start,
    input  logic [AW-1:0] req_addr,
    input  logic [W-1:0]  req_src,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [W-1:0]  mem_wdata,
    input  logic [W-1:0]  mem_rdata
);

    localparam int SHW = $clog2(W);

    rop_fn_e        cfg_fn;
    logic [W-1:0]   cfg_mask;
    logic [SHW-1:0] cfg_shamt;
    logic [W-1:0]   carry_word;
    logic [W-1:0]   aligned;
    rop_fn_e        op_fn;
    logic [W-1:0]   op_mask;
    logic [W-1:0]   op_src;

    rop_cfg_regs #(.W(W), .SHW(SHW)) cfg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .fn        (cfg_fn),
        .mask      (cfg_mask),
        .shamt     (cfg_shamt)
    );

    rop_funnel_shift #(.W(W), .SHW(SHW)) shift_i (
        .prev_word (carry_word),
        .cur_word  (req_src),
        .shamt     (cfg_shamt),
        .aligned   (aligned)
    );

    rop_rmw_ctrl #(.W(W), .AW(AW)) ctrl_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_line_start (req_line_start),
        .req_addr       (req_addr),
        .req_src        (req_src),
        .aligned        (aligned),
        .cfg_fn         (cfg_fn),
        .cfg_mask       (cfg_mask),
        .req_ready      (req_ready),
        .carry_word     (carry_word),
        .op_fn          (op_fn),
        .op_mask        (op_mask),
        .op_src         (op_src),
        .mem_en         (mem_en),
        .mem_we         (mem_we),
        .mem_addr       (mem_addr)
    );

    rop_logic_unit #(.W(W)) alu_i (
        .fn     (op_fn),
        .mask   (op_mask),
        .dst    (mem_rdata),
        .src    (op_src),
        .result (mem_wdata)
    );

endmodule

// File: rtl/rop_rmw_checker.sv
module rop_rmw_checker #(
    parameter int W  = 32,
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic [AW-1:0] req_addr,
    input logic          mem_en,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [W-1:0]  mem_wdata,
    input logic [W-1:0]  mem_rdata,
    input logic [W-1:0]  op_mask
);

    // R5
    accept_starts_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (mem_en && !mem_we && mem_addr == $past(req_addr)));

    // R5
    read_then_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_we) |=> (mem_en && mem_we && $stable(mem_addr)));

    // R5
    idle_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_en);

    // R6
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R6
    ready_after_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we) |=> req_ready);

    // R4
    masked_bits_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we) |-> (((mem_wdata ^ mem_rdata) & ~op_mask) == '0));

endmodule

bind rop_rmw_engine rop_rmw_checker #(.W(W), .AW(AW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .op_mask   (op_mask)
);

// File: tb/rop_rmw_engine_tb_top.sv
module rop_rmw_engine_tb_top;

    localparam int W  = 8;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = '0;
    logic [W-1:0]  cfg_wdata = '0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_line_start = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [W-1:0]  req_src = '0;
    logic          mem_en;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [W-1:0]  mem_wdata;
    logic [W-1:0]  mem_rdata = '0;

    logic [W-1:0]  mem_model [16];
    logic [W-1:0]  masks [4] = '{8'hFF, 8'h0F, 8'hA5, 8'h00};

    int  n_checks = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    rop_rmw_engine #(.W(W), .AW(AW)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_we         (cfg_we),
        .cfg_sel        (cfg_sel),
        .cfg_wdata      (cfg_wdata),
        .req_valid      (req_valid),
        .req_ready      (req_ready),
        .req_line_start (req_line_start),
        .req_addr       (req_addr),
        .req_src        (req_src),
        .mem_en         (mem_en),
        .mem_we         (mem_we),
        .mem_addr       (mem_addr),
        .mem_wdata      (mem_wdata),
        .mem_rdata      (mem_rdata)
    );

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) mem_model[mem_addr] <= mem_wdata;
            mem_rdata <= mem_model[mem_addr];
        end
    end

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rop(input logic [1:0] f, input logic [7:0] d,
                                           input logic [7:0] s, input logic [7:0] m);
        logic [7:0] r;
        case (f)
            2'd0:    r = s;
            2'd1:    r = d | s;
            2'd2:    r = d ^ s;
            default: r = d & ~s;
        endcase
        return (r & m) | (d & ~m);
    endfunction

    function automatic logic [7:0] exp_funnel(input logic [7:0] p, input logic [7:0] c,
                                              input int sh);
        logic [15:0] x;
        x = {p, c} >> sh;
        return x[7:0];
    endfunction

    task automatic set_cfg(input logic [1:0] sel, input logic [7:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_op(input logic [3:0] addr, input logic [7:0] src, input logic ls,
                         input bit mid, input logic [1:0] msel, input logic [7:0] mval);
        @(negedge clk);
        check("R6 ready before request", 8'(req_ready), 8'd1);
        req_valid = 1'b1; req_addr = addr; req_src = src; req_line_start = ls;
        @(negedge clk);
        req_valid = 1'b0; req_line_start = 1'b0;
        check("R6 busy in read", 8'(req_ready), 8'd0);
        check("R5 read phase en/we", 8'({mem_en, mem_we}), 8'b10);
        check("R5 read address", 8'(mem_addr), 8'(addr));
        if (mid) begin
            cfg_we = 1'b1; cfg_sel = msel; cfg_wdata = mval;
        end
        @(negedge clk);
        cfg_we = 1'b0;
        check("R6 busy in write", 8'(req_ready), 8'd0);
        check("R5 write phase en/we", 8'({mem_en, mem_we}), 8'b11);
        check("R5 write address", 8'(mem_addr), 8'(addr));
        @(negedge clk);
        check("R6 ready after write-back", 8'(req_ready), 8'd1);
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung, expected completion");
            report();
        end
    end

    initial begin
        logic [7:0] d, s, m, e, prev, cur;
        for (int i = 0; i < 16; i++) mem_model[i] = '0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state at the ports
        check("R1 ready after reset", 8'(req_ready), 8'd1);
        check("R1 mem idle after reset", 8'(mem_en), 8'd0);
        // R1: default function replace, mask all ones, shift zero, carry zero
        mem_model[1] = 8'h5A;
        do_op(4'd1, 8'hC3, 1'b0, 1'b0, 2'd0, 8'h00);
        check("R1 default config result", mem_model[1], 8'hC3);

        // R3 R4: sweep of functions, masks, destinations and sources
        for (int f = 0; f < 4; f++) begin
            set_cfg(2'd0, 8'(f));
            for (int mi = 0; mi < 4; mi++) begin
                m = masks[mi];
                set_cfg(2'd1, m);
                for (int di = 0; di < 16; di++) begin
                    for (int si = 0; si < 12; si++) begin
                        d = 8'(di * 17);
                        s = 8'(si * 23 + f);
                        mem_model[4'(di + si)] = d;
                        do_op(4'(di + si), s, 1'b1, 1'b0, 2'd0, 8'h00);
                        e = exp_rop(2'(f), d, s, m);
                        check("R3/R4 function and mask merge", mem_model[4'(di + si)], e);
                    end
                end
            end
        end

        // R7 R8 R9: funnel alignment across words, with line starts
        set_cfg(2'd0, 8'd0);
        set_cfg(2'd1, 8'hFF);
        for (int sh = 0; sh < 8; sh++) begin
            set_cfg(2'd2, 8'(sh));
            prev = 8'h00;
            for (int ln = 0; ln < 2; ln++) begin
                for (int k = 0; k < 3; k++) begin
                    cur = 8'(8'h3C + sh * 29 + k * 71 + ln * 5);
                    if (k == 0) prev = 8'h00;
                    mem_model[4'(k + 3 * ln)] = 8'h00;
                    do_op(4'(k + 3 * ln), cur, (k == 0), 1'b0, 2'd0, 8'h00);
                    check("R7/R8/R9 aligned source", mem_model[4'(k + 3 * ln)],
                          exp_funnel(prev, cur, sh));
                    prev = cur;
                end
            end
        end

        // R2: shift field takes only the low log2(W) bits (0xFB -> 3)
        set_cfg(2'd2, 8'hFB);
        mem_model[7] = 8'h00;
        do_op(4'd7, 8'hFF, 1'b1, 1'b0, 2'd0, 8'h00);
        check("R2 shift low bits", mem_model[7], 8'h1F);

        // R2: select code 3 changes nothing
        set_cfg(2'd2, 8'h00);
        set_cfg(2'd0, 8'd1);
        set_cfg(2'd1, 8'h0F);
        set_cfg(2'd3, 8'h00);
        mem_model[8] = 8'hA0;
        do_op(4'd8, 8'h05, 1'b1, 1'b0, 2'd0, 8'h00);
        check("R2 select 3 ignored", mem_model[8], 8'hA5);

        // R10: mask write during a transaction does not affect it
        set_cfg(2'd0, 8'd0);
        set_cfg(2'd1, 8'hFF);
        mem_model[9] = 8'h00;
        do_op(4'd9, 8'hFF, 1'b1, 1'b1, 2'd1, 8'h00);
        check("R10 snapshot mask in flight", mem_model[9], 8'hFF);
        mem_model[10] = 8'h3C;
        do_op(4'd10, 8'hC3, 1'b1, 1'b0, 2'd0, 8'h00);
        check("R10 new mask on next request", mem_model[10], 8'h3C);

        // R10: function write during a transaction does not affect it
        set_cfg(2'd1, 8'hFF);
        mem_model[11] = 8'hF0;
        do_op(4'd11, 8'h0F, 1'b1, 1'b1, 2'd0, 8'd3);
        check("R10 snapshot function in flight", mem_model[11], 8'h0F);
        mem_model[12] = 8'hF0;
        do_op(4'd12, 8'h30, 1'b1, 1'b0, 2'd0, 8'h00);
        check("R10 new function on next request", mem_model[12], 8'hC0);

        done = 1'b1;
        report();
    end

endmodule